// File: doc/BRIEF.md
# Limited PWM Edge Generator

This block produces one pulse per switching period on a single output. The pulse starts high at the beginning of each period and falls at a position taken from a 10-bit edge code. A signed modulation input can shift that falling edge, in a direction the configuration selects. While modulation is switched on, the shifted edge is held between a minimum high time and a minimum low time before the period ends. A disable bit keeps the output low.

All settings are written through a narrow register-write port into a shadow bank. Writes to the shadow bank change nothing at the output. A rising edge of a go bit copies the shadow bank into a pending slot. The active bank takes the pending settings at the next period boundary, so a pulse that has already started keeps its width. Time is counted in clock ticks. A fine step of 5 ns is `TICKS_PER_STEP` ticks, and the 40 ns unit is eight fine steps.

Top module: `pwm_edge_gen`

## Requirements
- R1: After reset both banks are zero, the output is low, and an active period length of zero keeps the output low.
- R2: Shadow writes change the output only after the go bit (address 2, bit 0) goes from 0 to 1. Writing go as 1 while it is already 1 commits nothing, and leaving it at a steady level commits nothing.
- R3: A commit takes effect at the next period boundary. A pulse already in progress ends at its old falling edge.
- R4: Register map: address 0 holds edge code bits [9:2]. Address 1 holds edge code bits [1:0] in data bits [3:2], modulation enable in bit 1 and modulation sign in bit 0. Address 2 holds fine resolution in bit 2, disable in bit 1 and go in bit 0. Address 3 holds minimum on code in bits [7:4] and minimum off code in bits [3:0]. Addresses 4 and 5 hold period ticks bits [7:0] and the bits above them.
- R5: Each period lasts the programmed number of ticks. The output is high from the period start for the effective edge in ticks and low for the rest of the period.
- R6: With fine resolution set to 1, one edge code step is `TICKS_PER_STEP` ticks. With it set to 0, one step is 8×`TICKS_PER_STEP` ticks.
- R7: With modulation enable at 0, the edge sits at the programmed value, and no minimum limit applies.
- R8: With modulation enabled, sign 1 adds `mod_in` ticks to the edge and sign 0 subtracts them. `mod_in` is sampled at each period start.
- R9: With modulation enabled, the high time is at least minimum on code × 16×`TICKS_PER_STEP` ticks.
- R10: With modulation enabled, the low time is at least 8×`TICKS_PER_STEP` ticks for minimum off code 0, and at least code × 16×`TICKS_PER_STEP` ticks for any other code. When the two limits conflict, the minimum low time wins.
- R11: With the disable bit set to 1 in the active bank, the output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| mod_in | input | MOD_W | Signed edge modulation in ticks |
| pwm_out | output | 1 | PWM output |

## Verification
The scoreboard measures complete high and low runs of the output and compares each pair against the expected widths. The edge is driven by the two resolutions, then by the two modulation signs, and then by values that push it below the minimum on limit, above the minimum off limit, and into a conflict between the two. Comparing these cases shows whether the step scale, the modulation direction and the precedence between the limits are right. Separate runs write go while it is already high, commit in the middle of a pulse, and program an edge outside the limits with modulation off. These runs show whether commit is edge-triggered, whether the update waits for the period boundary, and whether clamping is tied to modulation.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  localparam int EDGE_W = 10;
  localparam int LIM_W  = 4;

  typedef struct packed {
    logic [EDGE_W-1:0] edge_code;
    logic              mod_en;
    logic              mod_sign;
    logic              fine_res;
    logic              out_dis;
    logic [LIM_W-1:0]  min_on;
    logic [LIM_W-1:0]  min_off;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
  import pwm_edge_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output pwm_cfg_t         shd_cfg_d,
  output logic [CNT_W-1:0] shd_per_d,
  output logic             commit
);
  localparam int HI_W = CNT_W - 8;

  pwm_cfg_t         cfg_q;
  logic [CNT_W-1:0] per_q;
  logic             go_q, go_d;

  always_comb begin
    shd_cfg_d = cfg_q;
    shd_per_d = per_q;
    go_d      = go_q;
    if (wr_en) begin
      case (wr_addr)
        3'd0: shd_cfg_d.edge_code[EDGE_W-1:2] = wr_data;
        3'd1: begin
          shd_cfg_d.edge_code[1:0] = wr_data[3:2];
          shd_cfg_d.mod_en         = wr_data[1];
          shd_cfg_d.mod_sign       = wr_data[0];
        end
        3'd2: begin
          shd_cfg_d.fine_res = wr_data[2];
          shd_cfg_d.out_dis  = wr_data[1];
          go_d               = wr_data[0];
        end
        3'd3: begin
          shd_cfg_d.min_on  = wr_data[7:4];
          shd_cfg_d.min_off = wr_data[3:0];
        end
        3'd4: shd_per_d[7:0]       = wr_data;
        3'd5: shd_per_d[CNT_W-1:8] = wr_data[HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign commit = go_d & ~go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      per_q <= '0;
      go_q  <= 1'b0;
    end else if (wr_en) begin
      cfg_q <= shd_cfg_d;
      per_q <= shd_per_d;
      go_q  <= go_d;
    end
  end

  // R2: a commit always leaves the go bit high
  p_go_high_after_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> go_q);
  // R2: the go bit changes only on a write
  p_go_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(go_q));
endmodule

// File: rtl/pwm_edge_calc.sv
module pwm_edge_calc
  import pwm_edge_pkg::*;
#(
  parameter int TICKS_PER_STEP = 1,
  parameter int CNT_W          = 14,
  parameter int MOD_W          = 8,
  parameter int CALC_W         = 18
) (
  input  pwm_cfg_t                 cfg,
  input  logic [CNT_W-1:0]         period,
  input  logic signed [MOD_W-1:0]  mod_in,
  output logic [CALC_W-1:0]        edge_ticks
);
  localparam int TPU = 8 * TICKS_PER_STEP;

  logic signed [CALC_W-1:0] step, base, modv, moved, lo_lim, off_len, hi_lim, clamped;

  always_comb begin
    step    = cfg.fine_res ? CALC_W'(TICKS_PER_STEP) : CALC_W'(TPU);
    base    = $signed(CALC_W'(cfg.edge_code)) * step;
    modv    = CALC_W'(mod_in);
    moved   = cfg.mod_sign ? (base + modv) : (base - modv);
    lo_lim  = $signed(CALC_W'(cfg.min_on)) * $signed(CALC_W'(2 * TPU));
    off_len = (cfg.min_off == '0) ? CALC_W'(TPU)
                                  : $signed(CALC_W'(cfg.min_off)) * $signed(CALC_W'(2 * TPU));
    hi_lim  = $signed(CALC_W'(period)) - off_len;
    clamped = moved;
    if (clamped < lo_lim) clamped = lo_lim;
    if (clamped > hi_lim) clamped = hi_lim;
    if (clamped < 0)      clamped = '0;
    edge_ticks = cfg.mod_en ? $unsigned(clamped) : $unsigned(base);
  end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_edge_pkg::*;
#(
  parameter int TICKS_PER_STEP = 1,
  parameter int CNT_W          = 14,
  parameter int MOD_W          = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              wr_addr,
  input  logic [7:0]              wr_data,
  input  logic signed [MOD_W-1:0] mod_in,
  output logic                    pwm_out
);
  localparam int BASE_W = (CNT_W > 14) ? CNT_W : 14;
  localparam int CALC_W = BASE_W + $clog2(TICKS_PER_STEP + 1) + 2;

  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  pwm_cfg_t         shd_cfg_d;
  logic [CNT_W-1:0] shd_per_d;
  logic             commit;

  pwm_shadow_bank #(.CNT_W(CNT_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_ni),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .shd_cfg_d (shd_cfg_d),
    .shd_per_d (shd_per_d),
    .commit    (commit)
  );

  pwm_cfg_t          pend_q, pend_d, act_q, act_d, sel_cfg;
  logic [CNT_W-1:0]  pend_per_q, pend_per_d, act_per_q, act_per_d, sel_per;
  logic              pend_vld_q, pend_vld_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CALC_W-1:0] edge_q, edge_d, calc_edge;
  logic              wrap, take_pend;

  assign wrap      = (act_per_q == '0) || (cnt_q == act_per_q - CNT_W'(1));
  assign take_pend = wrap && pend_vld_q;
  assign sel_cfg   = take_pend ? pend_q : act_q;
  assign sel_per   = take_pend ? pend_per_q : act_per_q;

  pwm_edge_calc #(
    .TICKS_PER_STEP (TICKS_PER_STEP),
    .CNT_W          (CNT_W),
    .MOD_W          (MOD_W),
    .CALC_W         (CALC_W)
  ) u_calc (
    .cfg        (sel_cfg),
    .period     (sel_per),
    .mod_in     (mod_in),
    .edge_ticks (calc_edge)
  );

  always_comb begin
    pend_d     = pend_q;
    pend_per_d = pend_per_q;
    pend_vld_d = pend_vld_q;
    act_d      = act_q;
    act_per_d  = act_per_q;
    edge_d     = edge_q;
    cnt_d      = cnt_q + CNT_W'(1);
    if (wrap) begin
      cnt_d     = '0;
      act_d     = sel_cfg;
      act_per_d = sel_per;
      edge_d    = calc_edge;
      if (take_pend) pend_vld_d = 1'b0;
    end
    if (commit) begin
      pend_d     = shd_cfg_d;
      pend_per_d = shd_per_d;
      pend_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      pend_per_q <= '0;
      pend_vld_q <= 1'b0;
      act_q      <= '0;
      act_per_q  <= '0;
      edge_q     <= '0;
      cnt_q      <= '0;
    end else begin
      pend_q     <= pend_d;
      pend_per_q <= pend_per_d;
      pend_vld_q <= pend_vld_d;
      act_q      <= act_d;
      act_per_q  <= act_per_d;
      edge_q     <= edge_d;
      cnt_q      <= cnt_d;
    end
  end

  assign pwm_out = (act_per_q != '0) && !act_q.out_dis && (CALC_W'(cnt_q) < edge_q);

  // R5: the counter stays inside the active period
  p_cnt_in_period_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (act_per_q != '0) |-> (cnt_q < act_per_q));
  // R3: edge and active settings change only at a period boundary
  p_edge_held_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !wrap |=> ($stable(edge_q) && $stable(act_q) && $stable(act_per_q)));
  // R5: a pulse can only start at the period start
  p_rise_at_start_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(pwm_out) |-> (cnt_q == '0));
  // R3: a pending commit is consumed at the boundary
  p_pend_consumed_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (take_pend && !commit) |=> !pend_vld_q);
endmodule

// File: tb/test_pwm_edge_gen.sv
module test_pwm_edge_gen;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [2:0]        wr_addr;
  logic [7:0]        wr_data;
  logic signed [7:0] mod_in;
  logic              pwm_out;

  always #5 clk = ~clk;

  pwm_edge_gen i_pwm_edge_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mod_in  (mod_in),
    .pwm_out (pwm_out)
  );

  typedef struct {
    int    hi;
    int    lo;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   flush_req = 1'b0;
  bit   mon_on = 1'b0;
  bit   fine = 1'b1;
  bit   dis = 1'b0;

  // scoreboard monitor: measures full high and low runs
  logic prev = 1'b0;
  int   run_len = 0;
  bit   run_full = 1'b0;
  bit   hi_ok = 1'b0;
  int   hi_meas = 0;
  exp_t it;

  always @(negedge clk) begin
    if (flush_req) begin
      run_full  = 1'b0;
      hi_ok     = 1'b0;
      flush_req = 1'b0;
    end
    if (mon_on) begin
      if (pwm_out !== prev) begin
        if (prev == 1'b1 && run_full) begin
          hi_meas = run_len;
          hi_ok   = 1'b1;
        end else if (prev == 1'b0) begin
          if (run_full && hi_ok && exp_q.size() > 0) begin
            it = exp_q.pop_front();
            checks++;
            if (hi_meas != it.hi || run_len != it.lo) begin
              fails++;
              $display("FAIL %s: high=%0d low=%0d expected high=%0d low=%0d",
                       it.req, hi_meas, run_len, it.hi, it.lo);
            end
          end
          hi_ok = 1'b0;
        end
        run_len  = 1;
        run_full = 1'b1;
      end else begin
        run_len++;
      end
    end
    prev = pwm_out;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_edge(input int code, input bit me, input bit sg);
    logic [9:0] c = 10'(code);
    wr(3'd0, c[9:2]);
    wr(3'd1, {4'b0, c[1:0], me, sg});
  endtask

  task automatic set_period(input int p);
    logic [13:0] v = 14'(p);
    wr(3'd4, v[7:0]);
    wr(3'd5, {2'b0, v[13:8]});
  endtask

  task automatic do_commit();
    wr(3'd2, {5'b0, fine, dis, 1'b0});
    wr(3'd2, {5'b0, fine, dis, 1'b1});
  endtask

  task automatic settle();
    repeat (100) @(negedge clk);
  endtask

  task automatic expect_pulses(input int hi, input int lo, input string req);
    exp_t e;
    int   waited = 0;
    flush_req = 1'b1;
    @(negedge clk);
    e.hi = hi; e.lo = lo; e.req = req;
    repeat (3) exp_q.push_back(e);
    while (exp_q.size() > 0 && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    if (exp_q.size() > 0) begin
      checks++;
      fails++;
      $display("FAIL %s: pulses missing, actual remaining=%0d expected remaining=0 (high=%0d low=%0d)",
               req, exp_q.size(), hi, lo);
      exp_q.delete();
    end
  endtask

  task automatic check_low(input int n, input string req);
    int highs = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out !== 1'b0) highs++;
    end
    checks++;
    if (highs != 0) begin
      fails++;
      $display("FAIL %s: high samples actual=%0d expected=0", req, highs);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run not finished, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hc;
    logic l;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; mod_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1: reset state keeps the output low
    check_low(60, "R1");

    // R2: shadow writes without a go edge do nothing
    set_period(20);
    set_edge(5, 1'b0, 1'b0);
    wr(3'd3, 8'h00);
    check_low(60, "R2");

    // R4 R5 R6: fine step, edge 5 in a 20-tick period
    fine = 1'b1; dis = 1'b0;
    do_commit();
    settle();
    expect_pulses(5, 15, "R5");

    // R6: coarse step, code 1 is 8 ticks
    set_edge(1, 1'b0, 1'b0);
    fine = 1'b0;
    do_commit();
    settle();
    expect_pulses(8, 12, "R6");

    // R8: sign 1 moves later by mod_in
    fine = 1'b1;
    mod_in = 8'sd3;
    set_edge(5, 1'b1, 1'b1);
    do_commit();
    settle();
    expect_pulses(8, 12, "R8");

    // R8: sign 0 moves earlier by mod_in
    set_edge(5, 1'b1, 1'b0);
    do_commit();
    settle();
    expect_pulses(2, 18, "R8");

    // R2: writing go=1 while already high commits nothing
    set_edge(10, 1'b1, 1'b0);
    wr(3'd2, {5'b0, fine, dis, 1'b1});
    settle();
    expect_pulses(2, 18, "R2");
    do_commit();
    settle();
    expect_pulses(7, 13, "R2");

    // R9: minimum on-time raises the edge
    set_period(40);
    wr(3'd3, 8'h10);
    set_edge(5, 1'b1, 1'b0);
    do_commit();
    settle();
    expect_pulses(16, 24, "R9");

    // R10: minimum off-time code 0 is 8 ticks
    wr(3'd3, 8'h00);
    mod_in = 8'sd5;
    set_edge(30, 1'b1, 1'b1);
    do_commit();
    settle();
    expect_pulses(32, 8, "R10");

    // R10: minimum off-time code 1 is 16 ticks
    wr(3'd3, 8'h01);
    do_commit();
    settle();
    expect_pulses(24, 16, "R10");

    // R10: conflict, off-time wins over on-time
    wr(3'd3, 8'h30);
    mod_in = 8'sd0;
    set_edge(5, 1'b1, 1'b1);
    do_commit();
    settle();
    expect_pulses(32, 8, "R10");

    // R7: modulation off, no clamping
    mod_in = 8'sd9;
    set_edge(2, 1'b0, 1'b1);
    do_commit();
    settle();
    expect_pulses(2, 38, "R7");

    // R11: disable holds output low
    dis = 1'b1;
    do_commit();
    settle();
    check_low(120, "R11");
    dis = 1'b0;
    do_commit();
    settle();
    expect_pulses(2, 38, "R11");

    // R3: commit mid-pulse keeps current pulse width
    set_period(20);
    wr(3'd3, 8'h00);
    set_edge(5, 1'b0, 1'b0);
    do_commit();
    settle();
    set_edge(15, 1'b0, 1'b0);
    wr(3'd2, {5'b0, fine, dis, 1'b0});
    l = pwm_out;
    forever begin
      @(negedge clk);
      if (pwm_out && !l) break;
      l = pwm_out;
    end
    hc = 1;
    wr_en = 1'b1; wr_addr = 3'd2; wr_data = {5'b0, fine, dis, 1'b1};
    @(negedge clk);
    wr_en = 1'b0;
    forever begin
      if (!pwm_out) break;
      hc++;
      @(negedge clk);
    end
    checks++;
    if (hc != 5) begin
      fails++;
      $display("FAIL R3: in-flight pulse high actual=%0d expected=5", hc);
    end
    settle();
    expect_pulses(15, 5, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule